// File: doc/BRIEF.md
# Supply and Temperature Extremum Tracker

This block follows a stream of telemetry samples for a bank of power-supply rails and a small set of temperature sensors. Each rail sample carries a rail index, a voltage in millivolts and a current reading. Each temperature sample carries a sensor index and a temperature in hundredths of a degree, so 2500 stands for 25.00 degrees. For every rail the block keeps the highest and lowest voltage and the highest current it has seen. For every sensor it keeps the highest temperature and the most recent reading.

A rail sample with a voltage of exactly zero means the rail is switched off, and it leaves all three of that rail's trackers untouched. The host reads any tracker through a registered read port, and it can overwrite any peak or minimum tracker. Writing a tracker is how it is re-armed: writing zero to a peak, or full scale to a minimum, starts a fresh capture window. Rail and temperature samples can arrive in the same cycle, each path at most one sample per cycle.

Top module: `rxt_top`

## Requirements
- R1: After reset every voltage peak, current peak and temperature peak reads 0, every voltage minimum reads 0x7FFF, and every last-temperature register reads 2500.
- R2: A rail sample whose voltage is 0 leaves that rail's voltage peak, voltage minimum and current peak unchanged, whatever its current value.
- R3: A rail's voltage peak takes the sample voltage only when the voltage is nonzero and strictly greater than the stored peak.
- R4: A rail's voltage minimum takes the sample voltage only when the voltage is nonzero and strictly smaller than the stored minimum.
- R5: A rail's current peak takes the sample current only when the current is strictly greater than the stored peak and the same sample's voltage is nonzero.
- R6: A sensor's temperature peak takes a sample only when it is strictly greater than the stored peak; the last-temperature register takes every in-range sample.
- R7: A host write (wr_sel 0 = voltage peak, 1 = voltage minimum, 2 = current peak, 3 = temperature peak) loads wr_data into the addressed tracker on the next clock edge; in the cycle a write and a sample hit the same tracker, the written value is kept, while the channel's other trackers still follow the sample.
- R8: A rail sample with index 16 or more, a temperature sample with index 5 or more, and a host write addressed past the last channel of its kind change no tracker.
- R9: rd_data shows, one clock after rd_sel and rd_chan are presented, the addressed value (rd_sel 0 = voltage peak, 1 = voltage minimum, 2 = current peak, 3 = temperature peak, 4 = last temperature); a selector above 4 or an index past the last channel of the selected kind reads 0.
- R10: Rail and temperature samples presented in the same cycle are both applied, and a sample for one channel never changes another channel's trackers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_valid | input | 1 | Rail sample strobe |
| sup_chan | input | 5 | Rail index |
| sup_mv | input | 16 | Rail voltage, millivolts |
| sup_ma | input | 16 | Rail current reading |
| tmp_valid | input | 1 | Temperature sample strobe |
| tmp_chan | input | 3 | Sensor index |
| tmp_val | input | 16 | Temperature, hundredths of a degree |
| wr_en | input | 1 | Host tracker write strobe |
| wr_sel | input | 2 | Tracker kind to write |
| wr_chan | input | 5 | Channel to write |
| wr_data | input | 16 | Value to load |
| rd_sel | input | 3 | Value kind to read |
| rd_chan | input | 5 | Channel to read |
| rd_data | output | 16 | Registered read result |

## Verification
Directed sequences on one rail separate the strict comparisons from non-strict ones: a repeated voltage, a zero voltage with a large current, and a lower then higher voltage each leave a different fingerprint on peak, minimum and current peak. A write and a sample aimed at the same rail in one cycle shows whether the write wins only for its own tracker. Indices just past the last rail and sensor, for samples, writes and reads, expose truncated index decoding through channel 0. Long random streams, about one sample in six at zero voltage and with in-range and out-of-range indices mixed with random writes, are swept through the read port against a bench model.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  localparam int VAL_W = 16;
  typedef logic [VAL_W-1:0] val_t;

  // reset values
  localparam val_t MIN_RESET  = 16'h7FFF;
  localparam val_t TEMP_RESET = 16'd2500;

  // host write kinds
  localparam logic [1:0] WK_VPK  = 2'd0;
  localparam logic [1:0] WK_VMIN = 2'd1;
  localparam logic [1:0] WK_IPK  = 2'd2;
  localparam logic [1:0] WK_TPK  = 2'd3;

  // read kinds
  localparam logic [2:0] RK_VPK   = 3'd0;
  localparam logic [2:0] RK_VMIN  = 3'd1;
  localparam logic [2:0] RK_IPK   = 3'd2;
  localparam logic [2:0] RK_TPK   = 3'd3;
  localparam logic [2:0] RK_TLAST = 3'd4;

  // candidate replaces a held peak only when strictly above it
  function automatic logic tops(val_t cand, val_t held);
    return cand > held;
  endfunction

  // candidate replaces a held minimum only when strictly below it
  function automatic logic undercuts(val_t cand, val_t held);
    return cand < held;
  endfunction

  // a zero voltage marks a switched-off rail
  function automatic logic rail_live(val_t mv);
    return mv != '0;
  endfunction
endpackage

// File: rtl/rxt_supply_lane.sv
module rxt_supply_lane
  import rxt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp_hit,
  input  val_t samp_mv,
  input  val_t samp_ma,
  input  logic wr_vpk,
  input  logic wr_vmin,
  input  logic wr_ipk,
  input  val_t wr_data,
  output val_t vpk,
  output val_t vmin,
  output val_t ipk
);
  logic live;
  logic vpk_upd, vmin_upd, ipk_upd;

  assign live     = samp_hit && rail_live(samp_mv);
  assign vpk_upd  = live && tops(samp_mv, vpk);
  assign vmin_upd = live && undercuts(samp_mv, vmin);
  assign ipk_upd  = live && tops(samp_ma, ipk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpk  <= '0;
      vmin <= MIN_RESET;
      ipk  <= '0;
    end else begin
      if (wr_vpk)       vpk <= wr_data;
      else if (vpk_upd) vpk <= samp_mv;

      if (wr_vmin)       vmin <= wr_data;
      else if (vmin_upd) vmin <= samp_mv;

      if (wr_ipk)       ipk <= wr_data;
      else if (ipk_upd) ipk <= samp_ma;
    end
  end

  // R2
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_hit && samp_mv == '0 && !wr_vpk && !wr_vmin && !wr_ipk)
      |=> ($stable(vpk) && $stable(vmin) && $stable(ipk)));

  // R3
  vpk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vpk |=> vpk >= $past(vpk));

  // R4
  vmin_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vmin |=> vmin <= $past(vmin));

  // R5
  ipk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ipk |=> ipk >= $past(ipk));

  // R7
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vpk |=> vpk == $past(wr_data));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_hit && !wr_vpk && !wr_vmin && !wr_ipk)
      |=> ($stable(vpk) && $stable(vmin) && $stable(ipk)));
endmodule

// File: rtl/rxt_temp_lane.sv
module rxt_temp_lane
  import rxt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp_hit,
  input  val_t samp_val,
  input  logic wr_tpk,
  input  val_t wr_data,
  output val_t tpk,
  output val_t tlast
);
  logic tpk_upd;

  assign tpk_upd = samp_hit && tops(samp_val, tpk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpk   <= '0;
      tlast <= TEMP_RESET;
    end else begin
      if (wr_tpk)       tpk <= wr_data;
      else if (tpk_upd) tpk <= samp_val;

      if (samp_hit) tlast <= samp_val;
    end
  end

  // R6
  tpk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tpk |=> tpk >= $past(tpk));

  // R6
  tlast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_hit |=> tlast == $past(samp_val));

  // R7
  twr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tpk |=> tpk == $past(wr_data));
endmodule

// File: rtl/rxt_top.sv
module rxt_top
  import rxt_pkg::*;
#(
  parameter int N_SUP     = 16,
  parameter int N_TMP     = 5,
  parameter int SUP_IDX_W = 5,
  parameter int TMP_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sup_valid,
  input  logic [SUP_IDX_W-1:0] sup_chan,
  input  logic [15:0]          sup_mv,
  input  logic [15:0]          sup_ma,
  input  logic                 tmp_valid,
  input  logic [TMP_IDX_W-1:0] tmp_chan,
  input  logic [15:0]          tmp_val,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [SUP_IDX_W-1:0] wr_chan,
  input  logic [15:0]          wr_data,
  input  logic [2:0]           rd_sel,
  input  logic [SUP_IDX_W-1:0] rd_chan,
  output logic [15:0]          rd_data
);
  localparam logic [SUP_IDX_W-1:0] SUP_LIM = SUP_IDX_W'(N_SUP);
  localparam logic [TMP_IDX_W-1:0] TMP_LIM = TMP_IDX_W'(N_TMP);

  logic [N_SUP-1:0] sup_hit;
  logic [N_TMP-1:0] tmp_hit;
  val_t vpk_a  [N_SUP];
  val_t vmin_a [N_SUP];
  val_t ipk_a  [N_SUP];
  val_t tpk_a  [N_TMP];
  val_t tlast_a[N_TMP];
  val_t rd_next;

  for (genvar g = 0; g < N_SUP; g++) begin : g_sup
    logic wv, wn, wi;
    assign sup_hit[g] = sup_valid && (sup_chan == SUP_IDX_W'(g));
    assign wv = wr_en && (wr_chan == SUP_IDX_W'(g)) && (wr_sel == WK_VPK);
    assign wn = wr_en && (wr_chan == SUP_IDX_W'(g)) && (wr_sel == WK_VMIN);
    assign wi = wr_en && (wr_chan == SUP_IDX_W'(g)) && (wr_sel == WK_IPK);
    rxt_supply_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_hit (sup_hit[g]),
      .samp_mv  (sup_mv),
      .samp_ma  (sup_ma),
      .wr_vpk   (wv),
      .wr_vmin  (wn),
      .wr_ipk   (wi),
      .wr_data  (wr_data),
      .vpk      (vpk_a[g]),
      .vmin     (vmin_a[g]),
      .ipk      (ipk_a[g])
    );
  end

  for (genvar g = 0; g < N_TMP; g++) begin : g_tmp
    logic wt;
    assign tmp_hit[g] = tmp_valid && (tmp_chan == TMP_IDX_W'(g));
    assign wt = wr_en && (wr_chan == SUP_IDX_W'(g)) && (wr_sel == WK_TPK);
    rxt_temp_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_hit (tmp_hit[g]),
      .samp_val (tmp_val),
      .wr_tpk   (wt),
      .wr_data  (wr_data),
      .tpk      (tpk_a[g]),
      .tlast    (tlast_a[g])
    );
  end

  always_comb begin
    rd_next = '0;
    case (rd_sel)
      RK_VPK:  for (int i = 0; i < N_SUP; i++) if (rd_chan == SUP_IDX_W'(i)) rd_next = vpk_a[i];
      RK_VMIN: for (int i = 0; i < N_SUP; i++) if (rd_chan == SUP_IDX_W'(i)) rd_next = vmin_a[i];
      RK_IPK:  for (int i = 0; i < N_SUP; i++) if (rd_chan == SUP_IDX_W'(i)) rd_next = ipk_a[i];
      RK_TPK:  for (int i = 0; i < N_TMP; i++) if (rd_chan == SUP_IDX_W'(i)) rd_next = tpk_a[i];
      RK_TLAST: for (int i = 0; i < N_TMP; i++) if (rd_chan == SUP_IDX_W'(i)) rd_next = tlast_a[i];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  // R8
  sup_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_valid && sup_chan >= SUP_LIM) |-> (sup_hit == '0));

  // R8
  tmp_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_valid && tmp_chan >= TMP_LIM) |-> (tmp_hit == '0));

  // R10
  sup_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sup_hit));

  // R9
  rd_badsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel > RK_TLAST) |=> (rd_data == '0));

  // R9
  rd_oobchan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan >= SUP_LIM) |=> (rd_data == '0));
endmodule

// File: tb/rxt_top_bench.sv
`timescale 1ns/1ps
module rxt_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_valid = 1'b0;
  logic [4:0] sup_chan = '0;
  logic [15:0] sup_mv = '0, sup_ma = '0;
  logic tmp_valid = 1'b0;
  logic [2:0] tmp_chan = '0;
  logic [15:0] tmp_val = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [4:0] wr_chan = '0;
  logic [15:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [4:0] rd_chan = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  logic [15:0] m_vpk[16], m_vmin[16], m_ipk[16], m_tpk[5], m_tlast[5];

  always #2 clk = ~clk;

  rxt_top u_rxt_top (
    .clk(clk), .rst_n(rst_n),
    .sup_valid(sup_valid), .sup_chan(sup_chan), .sup_mv(sup_mv), .sup_ma(sup_ma),
    .tmp_valid(tmp_valid), .tmp_chan(tmp_chan), .tmp_val(tmp_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_chan(wr_chan), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_chan(rd_chan), .rd_data(rd_data)
  );

  function automatic logic [15:0] keep_hi(logic [15:0] held, logic [15:0] cand);
    return (cand > held) ? cand : held;
  endfunction

  function automatic logic [15:0] keep_lo(logic [15:0] held, logic [15:0] cand);
    return (cand < held) ? cand : held;
  endfunction

  function automatic logic [15:0] expect_rd(int sel, int ch);
    if (sel == 0 && ch < 16) return m_vpk[ch];
    if (sel == 1 && ch < 16) return m_vmin[ch];
    if (sel == 2 && ch < 16) return m_ipk[ch];
    if (sel == 3 && ch < 5)  return m_tpk[ch];
    if (sel == 4 && ch < 5)  return m_tlast[ch];
    return 16'h0000;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_vpk[i] = 0; m_vmin[i] = 16'h7FFF; m_ipk[i] = 0;
    end
    for (int i = 0; i < 5; i++) begin
      m_tpk[i] = 0; m_tlast[i] = 16'd2500;
    end
  endtask

  // one cycle of stimulus; the model takes the sample, then the write overrides
  task automatic step(bit sv, int sc, logic [15:0] mv, logic [15:0] ma,
                      bit tv, int tc, logic [15:0] tval,
                      bit we, int ws, int wc, logic [15:0] wd);
    sup_valid = sv; sup_chan = 5'(sc); sup_mv = mv; sup_ma = ma;
    tmp_valid = tv; tmp_chan = 3'(tc); tmp_val = tval;
    wr_en = we; wr_sel = 2'(ws); wr_chan = 5'(wc); wr_data = wd;
    if (sv && sc < 16 && mv != 0) begin
      m_vpk[sc]  = keep_hi(m_vpk[sc], mv);
      m_vmin[sc] = keep_lo(m_vmin[sc], mv);
      m_ipk[sc]  = keep_hi(m_ipk[sc], ma);
    end
    if (tv && tc < 5) begin
      m_tpk[tc] = keep_hi(m_tpk[tc], tval);
      m_tlast[tc] = tval;
    end
    if (we) begin
      if (ws == 0 && wc < 16) m_vpk[wc] = wd;
      if (ws == 1 && wc < 16) m_vmin[wc] = wd;
      if (ws == 2 && wc < 16) m_ipk[wc] = wd;
      if (ws == 3 && wc < 5)  m_tpk[wc] = wd;
    end
    @(negedge clk);
    sup_valid = 0; tmp_valid = 0; wr_en = 0;
  endtask

  task automatic check_rd(int sel, int ch, logic [15:0] exp, string req);
    rd_sel = 3'(sel); rd_chan = 5'(ch);
    @(posedge clk);
    @(negedge clk);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s sel=%0d ch=%0d actual=%h expected=%h", req, sel, ch, rd_data, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 16; c++) check_rd(s, c, expect_rd(s, c), req);
    for (int s = 3; s < 5; s++)
      for (int c = 0; c < 5; c++) check_rd(s, c, expect_rd(s, c), req);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values on every tracker
    sweep("R1");

    // R3 R4 R5: first live sample on rail 3
    step(1, 3, 16'd1000, 16'd50, 0, 0, 0, 0, 0, 0, 0);
    check_rd(0, 3, 16'd1000, "R3");
    check_rd(1, 3, 16'd1000, "R4");
    check_rd(2, 3, 16'd50, "R5");
    // R2: zero voltage with large current changes nothing
    step(1, 3, 16'd0, 16'd900, 0, 0, 0, 0, 0, 0, 0);
    check_rd(0, 3, 16'd1000, "R2");
    check_rd(1, 3, 16'd1000, "R2");
    check_rd(2, 3, 16'd50, "R2");
    // R3 R4: lower then higher voltage
    step(1, 3, 16'd800, 16'd10, 0, 0, 0, 0, 0, 0, 0);
    step(1, 3, 16'd1200, 16'd40, 0, 0, 0, 0, 0, 0, 0);
    check_rd(0, 3, 16'd1200, "R3");
    check_rd(1, 3, 16'd800, "R4");
    check_rd(2, 3, 16'd50, "R5");
    // R7: write and sample on the same rail in the same cycle
    step(1, 3, 16'd2000, 16'd60, 0, 0, 0, 1, 0, 3, 16'd5);
    check_rd(0, 3, 16'd5, "R7");
    check_rd(2, 3, 16'd60, "R7");
    // R7: re-arm the minimum
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 3, 16'h7FFF);
    check_rd(1, 3, 16'h7FFF, "R7");
    // R8: out-of-range rail sample and writes leave channel 0 alone
    step(1, 16, 16'd3000, 16'd3000, 1, 5, 16'd9000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 16, 16'h1234);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3, 5, 16'h4321);
    check_rd(0, 0, 16'd0, "R8");
    check_rd(1, 0, 16'h7FFF, "R8");
    check_rd(3, 0, 16'd0, "R8");
    check_rd(4, 0, 16'd2500, "R8");
    // R6 R10: temperature and rail sample in the same cycle
    step(1, 7, 16'd500, 16'd7, 1, 4, 16'd3100, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 4, 16'd2700, 0, 0, 0, 0);
    check_rd(3, 4, 16'd3100, "R6");
    check_rd(4, 4, 16'd2700, "R6");
    check_rd(0, 7, 16'd500, "R10");
    // R9: bad selector and index past the last channel read 0
    check_rd(5, 0, 16'd0, "R9");
    check_rd(7, 3, 16'd0, "R9");
    check_rd(3, 5, 16'd0, "R9");
    check_rd(0, 16, 16'd0, "R9");

    // random streams, swept against the model (R2..R8, R10)
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 300; k++) begin
        bit sv = ($urandom % 4) != 0;
        int sc = $urandom % 20;
        logic [15:0] mv = (($urandom % 6) == 0) ? 16'd0 : 16'($urandom);
        logic [15:0] ma = 16'($urandom);
        bit tv = ($urandom % 3) == 0;
        int tc = $urandom % 7;
        logic [15:0] tval = 16'($urandom % 12000);
        bit we = ($urandom % 16) == 0;
        int ws = $urandom % 4;
        int wc = $urandom % 18;
        logic [15:0] wd = 16'($urandom);
        step(sv, sc, mv, ma, tv, tc, tval, we, ws, wc, wd);
      end
      sweep("R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule